// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block sits between a microcontroller bus and the internal memories and logic arrays of a peripheral. It watches the address strobe, and once the strobe has been quiet for fifteen periods of the reference clock, it raises a power-down flag. While that flag is up, the address and data lines are frozen at the values they held just before, the logic-array inputs are frozen too, and every memory select is forced inactive. Internal storage and logic therefore see no transitions while the host sleeps. The first edge on the strobe wakes the block directly, without waiting for any bus decode.

A small power-control register is written at run time through a write-enable and data port. It holds the power-down enable, a turbo-disable flag that is presented as an output, and one blocking bit per logic-array input. A blocking bit freezes its line whether or not the block is powered down. A separate active-low chip-select input deselects the memories only. It leaves the bus lines and the logic arrays untouched.

Top module: `bus_idle_pwrdn`

## Requirements
- R1: After reset, pdn_o and turbo_off_o are 0 and the bus, select and logic-array outputs follow their inputs, because the enable and every blocking bit reset to 0.
- R2: While the enable bit (control bit 0) is 0, pdn_o stays 0 however long the strobe is idle.
- R3: With enable set, pdn_o stays 0 after the 17th rising edge that follows a strobe level change and becomes 1 after the 18th. This is two synchronizer stages, one change-detect stage and fifteen idle counts.
- R4: Any strobe level change clears the idle count. If pdn_o is 1, it stays 1 after the first rising edge that follows the change and falls to 0 after the second.
- R5: The idle count saturates at fifteen, so pdn_o stays 1 for as long as the strobe stays idle.
- R6: While pdn_o is 1, addr_o and data_o hold the values they carried before power-down, whatever addr_i and data_i do.
- R7: While pdn_o is 1, mem_sel_o is all zeros. After wake-up it follows mem_sel_i again.
- R8: When cs_n_i is 1, mem_sel_o is all zeros, while addr_o, data_o and la_o still follow their inputs.
- R9: Control bit 2+i set freezes la_o[i] at its last passed value, whether or not the block is powered down. The other lines still pass.
- R10: While pdn_o is 1, every la_o line holds its last passed value.
- R11: A write with cfg_we_i high takes effect at that rising edge. Control bit 1 set makes turbo_off_o 1, and setting bit 0 while the strobe is already idle raises pdn_o after that same edge.
- R12: When not blocked, addr_o, data_o and la_o equal addr_i, data_i and la_i within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Host address strobe, asynchronous |
| addr_i | input | ADDR_W | Host address |
| data_i | input | DATA_W | Host data |
| addr_o | output | ADDR_W | Address to memories and logic arrays |
| data_o | output | DATA_W | Data to memories and logic arrays |
| mem_sel_i | input | SEL_W | Decoded memory selects, active high |
| cs_n_i | input | 1 | External chip select, active low |
| mem_sel_o | output | SEL_W | Gated memory selects |
| la_i | input | LA_W | Blockable logic-array inputs |
| la_o | output | LA_W | Logic-array inputs after blocking |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | LA_W+2 | Control write data: bit 0 enable, bit 1 turbo disable, bits 2+ blocking |
| pdn_o | output | 1 | Power-down active |
| turbo_off_o | output | 1 | Turbo mode disabled |

## Verification
On every cycle, the assertions check how the idle counter clears, steps and saturates, that blocked lines stay frozen, that the selects are low during power-down, that power-down never appears with the enable clear, and that control writes land on the following edge. Only the bench scenarios can show the exact power-down and wake-up latencies measured from a strobe change, that the frozen values are the ones seen before blocking, and how chip select, blocking bits and power-down separate from one another.

// File: rtl/pwr_ctl_pkg.sv
`timescale 1ns/1ps
// Package: shared control-register layout for the bus-idle power-down block.
// Assumes: the register is the fixed fields followed by one blocking bit per line.
package pwr_ctl_pkg;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_TURBO_BIT = 1;
    localparam int CTL_BLK_LSB   = 2;
    localparam int CTL_FIXED     = 2;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
// Module: strobe_sync
// Brings the asynchronous strobe into the clock domain with two flops and
// flags any level change between successive synchronized samples.
// Assumes: strobe pulses last longer than one clock period.
module strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic act_o
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= strobe_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Activity is any difference between the two newest samples
    always_comb act_o = sync_q ^ prev_q;
endmodule

// File: rtl/idle_timer.sv
`timescale 1ns/1ps
// Module: idle_timer
// Counts clock periods without strobe activity, saturating at IDLE_LIMIT, and
// raises power-down when the limit is held, the enable is set and no activity
// is seen in the current cycle.
// Assumes: act_i comes from a synchronized change detector.
module idle_timer #(
    parameter int IDLE_LIMIT = 15,
    localparam int CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic en_i,
    output logic pdn_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Clear on activity, otherwise step until the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (act_i)          cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    // Power-down request; activity drops it in the same cycle
    always_comb pdn_o = en_i && (cnt_q == LIMIT) && !act_i;

    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (cnt_q == '0));
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i && cnt_q != LIMIT) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i && cnt_q == LIMIT) |=> (cnt_q == LIMIT));
endmodule

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
// Module: pwr_ctl_reg
// Run-time power-control register: enable, turbo-disable and per-line blocking.
// Assumes: a write is accepted on any edge where we_i is high; reset clears all.
module pwr_ctl_reg #(
    parameter int LA_W = 6,
    localparam int REG_W = pwr_ctl_pkg::CTL_FIXED + LA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             en_o,
    output logic             turbo_off_o,
    output logic [LA_W-1:0]  blk_o
);
    import pwr_ctl_pkg::*;

    logic [REG_W-1:0] ctl_q;

    // Register storage, fully cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (we_i) ctl_q <= wdata_i;
    end

    // Field decode
    always_comb begin
        en_o        = ctl_q[CTL_EN_BIT];
        turbo_off_o = ctl_q[CTL_TURBO_BIT];
        blk_o       = ctl_q[CTL_BLK_LSB +: LA_W];
    end

    p_turbo_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (turbo_off_o == $past(wdata_i[CTL_TURBO_BIT])));
    p_blk_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (blk_o == $past(wdata_i[CTL_BLK_LSB +: LA_W])));
endmodule

// File: rtl/hold_gate.sv
`timescale 1ns/1ps
// Module: hold_gate
// Per-line freeze: an unblocked line passes straight through and is captured
// each clock; a blocked line shows its last captured value.
// Assumes: blk_i is synchronous to clk.
module hold_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] blk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic hold_q;

        // Capture the live value while the line is not blocked
        always_ff @(posedge clk) begin
            if (!rst_n)         hold_q <= 1'b0;
            else if (!blk_i[i]) hold_q <= d_i[i];
        end

        // Select live or held value
        always_comb q_o[i] = blk_i[i] ? hold_q : d_i[i];

        p_frozen_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_i[i] && $past(blk_i[i])) |-> $stable(q_o[i]));
    end
endmodule

// File: rtl/bus_idle_pwrdn.sv
`timescale 1ns/1ps
// Module: bus_idle_pwrdn
// Top level: strobe idle detection, power-down gating of the bus and memory
// selects, per-line logic-array blocking and the power-control register.
// Assumes: all bus inputs other than the strobe are synchronous to clk.
module bus_idle_pwrdn #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 4,
    parameter int LA_W       = 6,
    parameter int IDLE_LIMIT = 15
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   strobe_i,
    input  logic [ADDR_W-1:0]                      addr_i,
    input  logic [DATA_W-1:0]                      data_i,
    output logic [ADDR_W-1:0]                      addr_o,
    output logic [DATA_W-1:0]                      data_o,
    input  logic [SEL_W-1:0]                       mem_sel_i,
    input  logic                                   cs_n_i,
    output logic [SEL_W-1:0]                       mem_sel_o,
    input  logic [LA_W-1:0]                        la_i,
    output logic [LA_W-1:0]                        la_o,
    input  logic                                   cfg_we_i,
    input  logic [pwr_ctl_pkg::CTL_FIXED+LA_W-1:0] cfg_wdata_i,
    output logic                                   pdn_o,
    output logic                                   turbo_off_o
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic            act;
    logic            apd_en;
    logic [LA_W-1:0] blk_bits;
    logic [BUS_W-1:0] bus_blk, bus_q;
    logic [LA_W-1:0]  la_blk;

    strobe_sync u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .act_o(act)
    );

    idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .act_i(act), .en_i(apd_en), .pdn_o(pdn_o)
    );

    pwr_ctl_reg #(.LA_W(LA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
        .en_o(apd_en), .turbo_off_o(turbo_off_o), .blk_o(blk_bits)
    );

    // Block masks: bus lines follow power-down, logic lines add their own bits
    always_comb begin
        bus_blk = {BUS_W{pdn_o}};
        la_blk  = blk_bits | {LA_W{pdn_o}};
    end

    hold_gate #(.W(BUS_W)) u_bus_gate (
        .clk(clk), .rst_n(rst_n), .blk_i(bus_blk),
        .d_i({addr_i, data_i}), .q_o(bus_q)
    );

    hold_gate #(.W(LA_W)) u_la_gate (
        .clk(clk), .rst_n(rst_n), .blk_i(la_blk), .d_i(la_i), .q_o(la_o)
    );

    // Split the gated bus and qualify the memory selects
    always_comb begin
        addr_o    = bus_q[DATA_W +: ADDR_W];
        data_o    = bus_q[DATA_W-1:0];
        mem_sel_o = (pdn_o || cs_n_i) ? '0 : mem_sel_i;
    end

    p_sel_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_o |-> (mem_sel_o == '0));
    p_no_pdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !apd_en |-> !pdn_o);
endmodule

// File: tb/bus_idle_pwrdn_bench.sv
`timescale 1ns/1ps
module bus_idle_pwrdn_bench;
    localparam int ADDR_W = 16, DATA_W = 8, SEL_W = 4, LA_W = 6;
    localparam int REG_W  = LA_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] data_o;
    logic [SEL_W-1:0]  sel_i = '0;
    logic              cs_n = 1'b0;
    logic [SEL_W-1:0]  sel_o;
    logic [LA_W-1:0]   la_i = '0;
    logic [LA_W-1:0]   la_o;
    logic              we = 1'b0;
    logic [REG_W-1:0]  wdata = '0;
    logic              pdn, turbo_off;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_idle_pwrdn u_bus_idle_pwrdn (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe),
        .addr_i(addr_i), .data_i(data_i), .addr_o(addr_o), .data_o(data_o),
        .mem_sel_i(sel_i), .cs_n_i(cs_n), .mem_sel_o(sel_o),
        .la_i(la_i), .la_o(la_o), .cfg_we_i(we), .cfg_wdata_i(wdata),
        .pdn_o(pdn), .turbo_off_o(turbo_off)
    );

    typedef enum int {S_PDN, S_TURBO, S_ADDR, S_DATA, S_SEL, S_LA} sel_e;
    typedef struct {
        sel_e        what;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];

    function automatic logic [31:0] probe(sel_e s);
        case (s)
            S_PDN:   return 32'(pdn);
            S_TURBO: return 32'(turbo_off);
            S_ADDR:  return 32'(addr_o);
            S_DATA:  return 32'(data_o);
            S_SEL:   return 32'(sel_o);
            default: return 32'(la_o);
        endcase
    endfunction

    // Driver side: queue an item, checked 2 ns after the next rising edge
    task automatic expect_v(sel_e s, logic [31:0] v, string r);
        item_t it;
        it.what = s; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic negs(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic write_ctl(logic [REG_W-1:0] v);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Monitor: compare queued expectations against the outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = probe(it.what);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s %s actual=%0h expected=%0h",
                             it.req, it.what.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a_old;
        logic [DATA_W-1:0] d_old;
        logic [LA_W-1:0]   la_old;
        addr_i = 16'h1234; data_i = 8'h5A; la_i = 6'h2B; sel_i = 4'b0101;
        negs(4);
        rst_n = 1'b1;
        // R1 reset state
        expect_v(S_PDN, 0, "R1"); expect_v(S_TURBO, 0, "R1");
        expect_v(S_ADDR, 32'h1234, "R1"); expect_v(S_SEL, 32'b0101, "R1");
        expect_v(S_LA, 32'h2B, "R1");
        negs(1);
        // R2 long idle with enable clear
        negs(30);
        expect_v(S_PDN, 0, "R2");
        negs(1);
        // R11 enable while already idle
        write_ctl(REG_W'(1));
        expect_v(S_PDN, 1, "R11");
        negs(1);
        // R4 wake latency, R3 power-down latency
        strobe = ~strobe;
        expect_v(S_PDN, 1, "R4");
        negs(1);
        expect_v(S_PDN, 0, "R4");
        negs(15);
        expect_v(S_PDN, 0, "R3");
        negs(1);
        expect_v(S_PDN, 1, "R3");
        negs(1);
        // R6 R7 R10 frozen while powered down
        a_old = addr_i; d_old = data_i; la_old = la_i;
        addr_i = 16'hBEEF; data_i = 8'hC3; la_i = 6'h14; sel_i = 4'b1111;
        expect_v(S_ADDR, 32'(a_old), "R6"); expect_v(S_DATA, 32'(d_old), "R6");
        expect_v(S_SEL, 0, "R7"); expect_v(S_LA, 32'(la_old), "R10");
        negs(1);
        // R5 saturation keeps power-down
        negs(40);
        expect_v(S_PDN, 1, "R5"); expect_v(S_ADDR, 32'(a_old), "R6");
        negs(1);
        // wake, then R12 and R7
        strobe = ~strobe;
        negs(2);
        expect_v(S_PDN, 0, "R4");
        expect_v(S_ADDR, 32'hBEEF, "R12"); expect_v(S_DATA, 32'hC3, "R12");
        expect_v(S_SEL, 32'b1111, "R7"); expect_v(S_LA, 32'h14, "R12");
        negs(1);
        write_ctl('0);
        // R8 chip select only drops the selects
        cs_n = 1'b1; addr_i = 16'h0F0F; la_i = 6'h3C;
        expect_v(S_SEL, 0, "R8"); expect_v(S_ADDR, 32'h0F0F, "R8");
        expect_v(S_LA, 32'h3C, "R8"); expect_v(S_PDN, 0, "R8");
        negs(1);
        cs_n = 1'b0;
        // R9 R11 block line 0 and disable turbo
        write_ctl(REG_W'({6'b000001, 2'b10}));
        expect_v(S_TURBO, 1, "R11");
        negs(1);
        la_i = 6'h03;
        expect_v(S_LA, 32'(6'h02 | (6'h3C & 6'h01)), "R9");
        negs(1);
        write_ctl('0);
        expect_v(S_TURBO, 0, "R11"); expect_v(S_LA, 32'h03, "R9");
        negs(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule